// File: doc/BRIEF.md
# I2C Bus Status Flag Monitor

This block observes an I2C bus whose clock and data lines have already been brought into the system clock domain. It does not drive the bus. It keeps three sticky status flags: a start flag, a stop flag and an acknowledge flag. It also reports how many clock pulses of the current byte have gone by. Start and stop conditions are recognised from data-line edges while the clock line is high. The pulse count tells the monitor where each acknowledge clock falls and where each byte boundary lies, so the address byte can be told apart from the bytes after it.

A small phase machine drives the count. It has three states:

- `PH_IDLE`: no transfer is open.
- `PH_ADDR`: the address byte is in progress.
- `PH_DATA`: a later byte is in progress.

Its transitions are:

- `T_OPEN`: any state goes to `PH_ADDR` on a start condition, including a repeated start.
- `T_CLOSE`: any state goes to `PH_IDLE` on a stop condition.
- `T_ABORT`: any state goes to `PH_IDLE` on a release pulse or while the block is disabled.
- `T_ADVANCE`: `PH_ADDR` goes to `PH_DATA` on the clock rise that follows the ninth pulse.
- `T_COUNT`: a clock rise inside `PH_ADDR` or `PH_DATA` steps the count 1 to 9 and wraps to 1.

Software uses the flags to follow bus activity. A release pulse ends the monitor's part in the transfer. Clearing the wake-up mode bit discards a stop indication. Disabling the block clears everything.

Top module: `i2c_bus_flag_mon`

## Requirements
- R1: While reset is asserted and right after it, all three flags are 0 and the byte count is 0.
- R2: A data fall while the clock stays high (a start) sets the start flag and sets the count to 0. Both are visible one clock after the input change.
- R3: Inside a transfer, each clock rise steps the count through 1..9, and the rise after 9 gives 1. Outside a transfer, clock rises leave the count at 0.
- R4: The acknowledge flag sets on the ninth clock rise of a byte when data is low at that rise. It stays 0 when data is high at that rise.
- R5: The acknowledge flag clears on the first clock rise of the next byte and on a stop condition.
- R6: The start flag stays set through the whole address byte. It clears on the first clock rise of the byte after the address byte, and it also clears on a stop condition.
- R7: A data rise while the clock stays high (a stop) sets the stop flag and returns the count to 0. The stop flag stays set across a later start and across clock rises outside a transfer. It clears on the first clock rise of the address byte that follows a start.
- R8: When the wake-up mode bit goes from 1 to 0, the stop flag clears. This clear wins over a stop condition in the same cycle.
- R9: A release pulse clears the start flag, the acknowledge flag and the count, and it ends the transfer, so later clock rises are not counted until a new start. The stop flag is kept.
- R10: While enable is 0, all flags and the count are held at 0 and bus events are ignored. This takes effect one clock after enable falls.
- R11: A repeated start during a transfer sets the start flag again and sets the count to 0. The next byte is then treated as an address byte.
- R12: A release pulse in the same cycle as a start condition wins: the start flag stays 0 and no transfer opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Synchronized bus clock line |
| sda_in | input | 1 | Synchronized bus data line |
| enable | input | 1 | Block enable; 0 holds everything cleared |
| release_pulse | input | 1 | One-cycle request to leave the current transfer |
| wake_mode | input | 1 | Wake-up mode bit; its 1-to-0 change clears the stop flag |
| start_flag | output | 1 | Start condition seen; address byte in progress |
| stop_flag | output | 1 | Stop condition seen; bus released |
| ack_flag | output | 1 | Acknowledge seen on the ninth clock |
| bit_count | output | CNT_W | Clock pulses seen in the current byte (0..9) |

## Verification
Every result of this block is due on the first system clock edge after the input change that causes it. This holds for a start, a stop, a counted clock rise, a release pulse, a wake-bit fall and the fall of enable, because the events are decoded from the present input against a one-cycle-old copy and the flag registers take them at that same edge. The bench changes inputs one nanosecond after a rising edge. It then reads the outputs one nanosecond after the next rising edge, so every check falls exactly one edge after its stimulus. The sweep over byte counts and acknowledge patterns computes the expected count, start, stop and acknowledge values from the byte and pulse index alone.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    // Transfer phase as tracked by the byte sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    // Single-cycle bus events decoded from the synchronized lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
    } bus_ev_t;

endpackage

// File: rtl/i2c_mon_edge.sv
module i2c_mon_edge
    import i2c_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    // One-cycle history of both lines; idle bus is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Data edges while clock is high on both samples are conditions
    always_comb begin
        ev.start    = scl_q & scl & sda_q & ~sda;
        ev.stop     = scl_q & scl & ~sda_q & sda;
        ev.scl_rise = ~scl_q & scl;
    end

endmodule

// File: rtl/i2c_mon_seq.sv
module i2c_mon_seq
    import i2c_mon_pkg::*;
#(
    parameter int CLKS_PER_BYTE = 9,
    parameter int CNT_W         = $clog2(CLKS_PER_BYTE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_ev_t          ev,
    input  logic             abort,
    output logic [CNT_W-1:0] cnt,
    output logic             addr_first_clk,
    output logic             post_addr_clk,
    output logic             next_byte_clk,
    output logic             ack_clk
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BYTE);
    localparam logic [CNT_W-1:0] PRE  = CNT_W'(CLKS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             in_xfer;

    assign in_xfer = (phase_q != PH_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= ZERO;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: T_ABORT, T_OPEN, T_CLOSE, T_COUNT, T_ADVANCE
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (abort) begin
            phase_d = PH_IDLE;
            cnt_d   = ZERO;
        end else if (ev.start) begin
            phase_d = PH_ADDR;
            cnt_d   = ZERO;
        end else if (ev.stop) begin
            phase_d = PH_IDLE;
            cnt_d   = ZERO;
        end else if (ev.scl_rise) begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_d = ZERO;
                end
                PH_ADDR: begin
                    if (cnt_q == LAST) begin
                        cnt_d   = ONE;
                        phase_d = PH_DATA;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                PH_DATA: begin
                    cnt_d = (cnt_q == LAST) ? ONE : cnt_q + ONE;
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_d   = ZERO;
                end
            endcase
        end
    end

    // Outputs: position pulses qualified by the current phase
    always_comb begin
        cnt            = cnt_q;
        addr_first_clk = 1'b0;
        post_addr_clk  = 1'b0;
        next_byte_clk  = 1'b0;
        ack_clk        = 1'b0;
        if (ev.scl_rise && !abort && !ev.start && !ev.stop) begin
            unique case (phase_q)
                PH_IDLE: ;
                PH_ADDR: begin
                    addr_first_clk = (cnt_q == ZERO);
                    post_addr_clk  = (cnt_q == LAST);
                    next_byte_clk  = (cnt_q == LAST);
                    ack_clk        = (cnt_q == PRE);
                end
                PH_DATA: begin
                    next_byte_clk  = (cnt_q == LAST);
                    ack_clk        = (cnt_q == PRE);
                end
                default: ;
            endcase
        end
    end

    // R3: the count never exceeds the pulses of one byte
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: no count outside a transfer
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (cnt_q == ZERO));

    // R3: a counted rise never leaves the count at zero
    p_counted_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.scl_rise && in_xfer && !abort && !ev.start && !ev.stop) |=> (cnt_q != ZERO));

endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags #(
    parameter int CLKS_PER_BYTE = 9,
    parameter int CNT_W         = $clog2(CLKS_PER_BYTE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             release_pulse,
    input  logic             wake_mode,
    input  logic             sda,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             addr_first_clk,
    input  logic             post_addr_clk,
    input  logic             next_byte_clk,
    input  logic             ack_clk,
    input  logic [CNT_W-1:0] cnt,
    output logic             start_flag,
    output logic             stop_flag,
    output logic             ack_flag
);

    localparam logic [CNT_W-1:0] PRE = CNT_W'(CLKS_PER_BYTE - 1);

    logic start_q, start_d;
    logic stop_q,  stop_d;
    logic ack_q,   ack_d;
    logic wake_q;
    logic wake_fall;
    logic hard_clr;

    assign wake_fall = wake_q & ~wake_mode;
    assign hard_clr  = ~enable | release_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            ack_q   <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            start_q <= start_d;
            stop_q  <= stop_d;
            ack_q   <= ack_d;
            wake_q  <= wake_mode;
        end
    end

    // Start flag: hard clear, then set, then soft clear
    always_comb begin
        start_d = start_q;
        if (hard_clr)
            start_d = 1'b0;
        else if (start_ev)
            start_d = 1'b1;
        else if (stop_ev || post_addr_clk)
            start_d = 1'b0;
    end

    // Stop flag: release leaves it alone
    always_comb begin
        stop_d = stop_q;
        if (!enable || wake_fall)
            stop_d = 1'b0;
        else if (stop_ev)
            stop_d = 1'b1;
        else if (addr_first_clk)
            stop_d = 1'b0;
    end

    // Acknowledge flag
    always_comb begin
        ack_d = ack_q;
        if (hard_clr)
            ack_d = 1'b0;
        else if (stop_ev || next_byte_clk)
            ack_d = 1'b0;
        else if (ack_clk && !sda)
            ack_d = 1'b1;
    end

    assign start_flag = start_q;
    assign stop_flag  = stop_q;
    assign ack_flag   = ack_q;

    // R4: acknowledge only appears on the rise leaving pulse eight
    p_ack_at_ninth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> ($past(cnt) == PRE));

    // R7: stop flag persists until one of its clear events
    p_stop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && enable && !addr_first_clk && !wake_fall) |=> stop_q);

    // R9: release empties start and acknowledge
    p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> (!start_q && !ack_q));

    // R8: wake-bit fall empties the stop flag
    p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_fall |=> !stop_q);

endmodule

// File: rtl/i2c_bus_flag_mon.sv
module i2c_bus_flag_mon
    import i2c_mon_pkg::*;
#(
    parameter  int CLKS_PER_BYTE = 9,
    localparam int CNT_W         = $clog2(CLKS_PER_BYTE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             enable,
    input  logic             release_pulse,
    input  logic             wake_mode,
    output logic             start_flag,
    output logic             stop_flag,
    output logic             ack_flag,
    output logic [CNT_W-1:0] bit_count
);

    bus_ev_t ev;
    logic    abort;
    logic    addr_first_clk;
    logic    post_addr_clk;
    logic    next_byte_clk;
    logic    ack_clk;

    assign abort = ~enable | release_pulse;

    i2c_mon_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (scl_in),
        .sda   (sda_in),
        .ev    (ev)
    );

    i2c_mon_seq #(
        .CLKS_PER_BYTE (CLKS_PER_BYTE),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev             (ev),
        .abort          (abort),
        .cnt            (bit_count),
        .addr_first_clk (addr_first_clk),
        .post_addr_clk  (post_addr_clk),
        .next_byte_clk  (next_byte_clk),
        .ack_clk        (ack_clk)
    );

    i2c_mon_flags #(
        .CLKS_PER_BYTE (CLKS_PER_BYTE),
        .CNT_W         (CNT_W)
    ) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .release_pulse  (release_pulse),
        .wake_mode      (wake_mode),
        .sda            (sda_in),
        .start_ev       (ev.start),
        .stop_ev        (ev.stop),
        .addr_first_clk (addr_first_clk),
        .post_addr_clk  (post_addr_clk),
        .next_byte_clk  (next_byte_clk),
        .ack_clk        (ack_clk),
        .cnt            (bit_count),
        .start_flag     (start_flag),
        .stop_flag      (stop_flag),
        .ack_flag       (ack_flag)
    );

    // R10: a disabled block shows nothing on the next cycle
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_flag && !stop_flag && !ack_flag && bit_count == '0));

endmodule

// File: tb/i2c_bus_flag_mon_tb_top.sv
module i2c_bus_flag_mon_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       en = 1'b1;
    logic       rel = 1'b0;
    logic       wake = 1'b0;
    logic       st_f, sp_f, ak_f;
    logic [3:0] cnt;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    i2c_bus_flag_mon dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda),
        .enable        (en),
        .release_pulse (rel),
        .wake_mode     (wake),
        .start_flag    (st_f),
        .stop_flag     (sp_f),
        .ack_flag      (ak_f),
        .bit_count     (cnt)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got %0d expected %0d", rq, got, exp);
        end
    endtask

    // One bit: lower clock, set data, raise clock; caller checks after the rise
    task automatic bit_rise(input logic v);
        scl = 1'b0; tick;
        sda = v;    tick;
        scl = 1'b1; tick;
    endtask

    task automatic start_cond;
        scl = 1'b0; tick;
        sda = 1'b1; tick;
        scl = 1'b1; tick;
        sda = 1'b0; tick;
    endtask

    task automatic stop_cond;
        scl = 1'b0; tick;
        sda = 1'b0; tick;
        scl = 1'b1; tick;
        sda = 1'b1; tick;
    endtask

    // Nine pulses with acknowledge (data low) on the last
    task automatic byte_acked;
        for (int k = 1; k <= 9; k++) bit_rise((k == 9) ? 1'b0 : k[0]);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick; tick;
        chk("R1 start in reset", int'(st_f), 0);
        chk("R1 count in reset", int'(cnt), 0);
        rst_n = 1'b1;
        tick;
        chk("R1 start after reset", int'(st_f), 0);
        chk("R1 stop after reset", int'(sp_f), 0);
        chk("R1 ack after reset", int'(ak_f), 0);
        chk("R1 count after reset", int'(cnt), 0);

        // Sweep: byte counts 1..3, every acknowledge pattern
        for (int nb = 1; nb <= 3; nb++) begin
            for (int mask = 0; mask < (1 << nb); mask++) begin
                stop_cond;
                chk("R7 stop set", int'(sp_f), 1);
                chk("R7 count cleared by stop", int'(cnt), 0);
                chk("R5 ack cleared by stop", int'(ak_f), 0);
                chk("R6 start cleared by stop", int'(st_f), 0);
                start_cond;
                chk("R2 start set", int'(st_f), 1);
                chk("R2 count zero", int'(cnt), 0);
                chk("R7 stop kept over start", int'(sp_f), 1);
                for (int b = 0; b < nb; b++) begin
                    for (int k = 1; k <= 9; k++) begin
                        logic ab;
                        ab = logic'((mask >> b) & 1);
                        bit_rise((k == 9) ? ~ab : logic'((b + k + mask) & 1));
                        chk("R3 count", int'(cnt), k);
                        chk("R6 start flag", int'(st_f), (b == 0) ? 1 : 0);
                        chk("R7 stop cleared at address", int'(sp_f), 0);
                        chk("R4 R5 ack flag", int'(ak_f), (k == 9 && ab) ? 1 : 0);
                    end
                end
            end
        end
        stop_cond;

        // Rises outside a transfer
        bit_rise(1'b1);
        chk("R3 idle rise ignored", int'(cnt), 0);
        chk("R7 stop kept by idle rise", int'(sp_f), 1);

        // Wake-bit fall
        wake = 1'b1; tick;
        chk("R8 stop before wake fall", int'(sp_f), 1);
        wake = 1'b0; tick;
        chk("R8 stop cleared by wake fall", int'(sp_f), 0);

        // Wake-bit fall together with stop
        scl = 1'b0; tick; sda = 1'b0; tick; scl = 1'b1; tick;
        wake = 1'b1; tick;
        sda = 1'b1; wake = 1'b0; tick;
        chk("R8 wake fall beats stop", int'(sp_f), 0);

        // Release right after start keeps stop
        stop_cond;
        start_cond;
        rel = 1'b1; tick; rel = 1'b0;
        chk("R9 start cleared", int'(st_f), 0);
        chk("R9 stop kept", int'(sp_f), 1);
        chk("R9 count cleared", int'(cnt), 0);
        bit_rise(1'b1);
        chk("R9 rise not counted", int'(cnt), 0);
        chk("R9 stop still kept", int'(sp_f), 1);

        // Release after acknowledge
        stop_cond;
        start_cond;
        byte_acked;
        chk("R4 ack set", int'(ak_f), 1);
        rel = 1'b1; tick; rel = 1'b0;
        chk("R9 ack cleared", int'(ak_f), 0);
        chk("R9 count cleared mid", int'(cnt), 0);

        // Disable
        stop_cond;
        start_cond;
        byte_acked;
        chk("R10 ack before disable", int'(ak_f), 1);
        en = 1'b0; tick;
        chk("R10 ack cleared", int'(ak_f), 0);
        chk("R10 start cleared", int'(st_f), 0);
        chk("R10 stop cleared", int'(sp_f), 0);
        chk("R10 count cleared", int'(cnt), 0);
        stop_cond;
        chk("R10 stop ignored", int'(sp_f), 0);
        start_cond;
        chk("R10 start ignored", int'(st_f), 0);
        bit_rise(1'b0);
        chk("R10 rise ignored", int'(cnt), 0);
        en = 1'b1; tick;
        chk("R10 still clear after enable", int'(st_f) + int'(sp_f) + int'(ak_f), 0);

        // Repeated start
        stop_cond;
        start_cond;
        byte_acked;
        for (int k = 1; k <= 4; k++) bit_rise(1'b1);
        chk("R3 count in second byte", int'(cnt), 4);
        start_cond;
        chk("R11 start set again", int'(st_f), 1);
        chk("R11 count zero", int'(cnt), 0);
        byte_acked;
        chk("R11 start held through address", int'(st_f), 1);
        chk("R11 count at nine", int'(cnt), 9);
        bit_rise(1'b1);
        chk("R11 start cleared after address", int'(st_f), 0);
        chk("R11 count wraps", int'(cnt), 1);
        chk("R5 ack cleared on next byte", int'(ak_f), 0);

        // Release same cycle as start
        stop_cond;
        sda = 1'b0; rel = 1'b1; tick; rel = 1'b0;
        chk("R12 start stays clear", int'(st_f), 0);
        chk("R12 count zero", int'(cnt), 0);
        bit_rise(1'b1);
        chk("R12 no transfer opened", int'(cnt), 0);
        chk("R12 stop flag kept", int'(sp_f), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule